// File: doc/BRIEF.md
# Fuse Programming Request Controller

This block takes requests to blow one bit of a one-time-programmable fuse store. Software writes a packed address word over a simple 32-bit register bus. The controller checks whether the request is allowed by running a fixed series of permission tests. When every test passes, it raises a single-bit burn request toward the fuse-array port and holds it until the array acknowledges. The array is not part of this block; it is seen only as a port that answers with success or failure.

Each request ends with a done flag. An error flag is also set when the request was refused or the burn failed. Both flags sit in a write-one-to-clear status register, and a mask register selects which of them drive the interrupt line. A key-protected lock register guards the other registers: while it is set, their bus writes are dropped and any program request is refused. Two fuse-derived inputs take part in the checks. One is the helper-data write-lock fuse, which guards the upper arrays. The other is the key-store write-lock status, which guards rows 24 to 31 of array 0.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset the lock reads 1 (offset 0x00 bit 0), the configuration reads 0 (offset 0x04), status reads 0 (offset 0x0C), the mask reads 3 (offset 0x10), and both `irq` and `fuse_req` are low.
- R2: The program word written at offset 0x08 packs the array select in bits 12:11, the row in bits 10:5 and the column in bits 4:0. Select 0 drives `fuse_array`=0, select 2 drives 1, select 3 drives 2, and `fuse_bit` = row*32+column. Select 1 is refused.
- R3: A write at offset 0x00 whose low 16 bits equal 0xDF0D clears the lock. Any other value sets it.
- R4: While the lock is set, writes at offsets 0x04, 0x0C and 0x10 leave those registers unchanged, and a program write is refused.
- R5: A program write is refused when configuration bit 1 (program enable) is clear.
- R6: For selects 2 and 3, a program write is refused when `hd_lock_fuse` is high.
- R7: For select 0 with row 24 to 31, a program write is refused when `ks_wr_lock` is high.
- R8: An accepted request holds `fuse_req` high, with a stable `fuse_array`/`fuse_bit`, until `fuse_ack`. That cycle then sets done (status bit 0) and sets error (status bit 1) to the inverse of `fuse_ok`.
- R9: A refused request sets done and error in the cycle after the write and never raises `fuse_req`.
- R10: Writing ones to status bits 0 and 1 clears them. A completion in the same cycle takes precedence over the clear.
- R11: Mask bits 1:0 at offset 0x10 are read/write, and `irq` is high exactly when status AND mask is nonzero.
- R12: Status bit 2 reads 1 while a request is outstanding. Program writes during that time are ignored and change neither the outputs nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hd_lock_fuse | input | 1 | Helper-data write-lock fuse state |
| ks_wr_lock | input | 1 | Key-store write-lock status |
| fuse_req | output | 1 | Burn request to the fuse array |
| fuse_array | output | 2 | Physical array of the requested bit |
| fuse_bit | output | 11 | Linear bit index row*32+column |
| fuse_ack | input | 1 | Fuse array finished the burn |
| fuse_ok | input | 1 | Burn result, valid with `fuse_ack` |
| irq | output | 1 | Masked status interrupt |

## Verification
The refusals are the hardest cases to reach. Each check can only be seen failing when every check ahead of it passes, so an error caused by the key-store range needs all of the following at once: the lock open, program enable set, select 0, a row in 24..31 and `ks_wr_lock` high. The random loop draws rows with a bias toward that window and sets each gating input independently, so every check in turn becomes the first to fail. Directed sequences cover a program write arriving while a burn is outstanding, and register writes made under lock.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int SEL_W  = 2;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 5;
    localparam int BIT_W  = ROW_W + COL_W;
    localparam int WORD_W = SEL_W + ROW_W + COL_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pgm_word_t;

    typedef enum logic [2:0] {
        CHK_PASS,
        CHK_BAD_ADDR,
        CHK_LOCKED,
        CHK_DISABLED,
        CHK_HD_LOCK,
        CHK_KS_LOCK
    } chk_result_e;

    function automatic logic sel_valid(input logic [SEL_W-1:0] sel);
        return sel != 2'd1;
    endfunction

    function automatic logic [SEL_W-1:0] phys_array(input logic [SEL_W-1:0] sel);
        return (sel == 2'd0) ? 2'd0 : sel - 2'd1;
    endfunction

    function automatic logic [BIT_W-1:0] lin_bit(input pgm_word_t w);
        return {w.row, w.col};
    endfunction

endpackage

// File: rtl/fpc_lock.sv
module fpc_lock #(
    parameter int          KEY_W = 16,
    parameter logic [15:0] KEY   = 16'hDF0D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_we,
    input  logic [KEY_W-1:0] lock_wdata,
    output logic             locked
);
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b1;
        else if (lock_we)
            locked <= (lock_wdata != KEY[KEY_W-1:0]);
    end

    a_r3_wrong_key_locks: assert property (@(posedge clk) disable iff (rst)
        (lock_we && lock_wdata != KEY[KEY_W-1:0]) |=> locked);
    a_r3_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        (lock_we && lock_wdata == KEY[KEY_W-1:0]) |=> !locked);
endmodule

// File: rtl/fpc_check.sv
module fpc_check
    import fpc_pkg::*;
#(
    parameter int KS_ROW_LO = 24,
    parameter int KS_ROW_HI = 31
) (
    input  pgm_word_t         word,
    input  logic              locked,
    input  logic              pgm_en,
    input  logic              hd_lock,
    input  logic              ks_lock,
    output chk_result_e       result,
    output logic [SEL_W-1:0]  arr,
    output logic [BIT_W-1:0]  bidx
);
    logic upper_arr;
    logic in_ks;

    always_comb begin
        upper_arr = (word.sel == 2'd2) || (word.sel == 2'd3);
        in_ks     = (word.sel == 2'd0) &&
                    (int'(word.row) >= KS_ROW_LO) && (int'(word.row) <= KS_ROW_HI);
        arr       = phys_array(word.sel);
        bidx      = lin_bit(word);
        if (!sel_valid(word.sel))
            result = CHK_BAD_ADDR;
        else if (locked)
            result = CHK_LOCKED;
        else if (!pgm_en)
            result = CHK_DISABLED;
        else if (upper_arr && hd_lock)
            result = CHK_HD_LOCK;
        else if (in_ks && ks_lock)
            result = CHK_KS_LOCK;
        else
            result = CHK_PASS;
    end
endmodule

// File: rtl/fpc_status.sv
module fpc_status #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic             ev_err,
    input  logic             w1c_we,
    input  logic [NFLAG-1:0] w1c_bits,
    input  logic             mask_we,
    input  logic [NFLAG-1:0] mask_bits,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] mask,
    output logic             irq
);
    logic [NFLAG-1:0] clr;
    logic [NFLAG-1:0] nxt;

    always_comb begin
        clr = w1c_we ? w1c_bits : '0;
        nxt = flags & ~clr;
        if (ev_valid) begin
            nxt[0] = 1'b1;
            nxt[1] = ev_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '1;
        end else begin
            flags <= nxt;
            if (mask_we)
                mask <= mask_bits;
        end
    end

    assign irq = |(flags & mask);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> flags[0]);
    a_r11_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && mask[0] && !mask_we) |=> irq);
    a_r10_clear_done: assert property (@(posedge clk) disable iff (rst)
        (w1c_we && w1c_bits[0] && !ev_valid) |=> !flags[0]);
endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [15:0] UNLOCK_KEY = 16'hDF0D,
    parameter int          KS_ROW_LO = 24,
    parameter int          KS_ROW_HI = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hd_lock_fuse,
    input  logic              ks_wr_lock,
    output logic              fuse_req,
    output logic [1:0]        fuse_array,
    output logic [10:0]       fuse_bit,
    input  logic              fuse_ack,
    input  logic              fuse_ok,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFF_LOCK = 'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 'h04;
    localparam logic [ADDR_W-1:0] OFF_PGM  = 'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 'h0C;
    localparam logic [ADDR_W-1:0] OFF_MASK = 'h10;
    localparam int                NFLAG    = 2;

    logic             locked;
    logic             cfg_en;
    pgm_word_t        word_q;
    pgm_word_t        word_in;
    chk_result_e      chk;
    logic [SEL_W-1:0] chk_arr;
    logic [BIT_W-1:0] chk_bit;
    logic             busy;
    logic             pgm_we;
    logic             ev_valid;
    logic             ev_err;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] mask;

    assign word_in = pgm_word_t'(bus_wdata[WORD_W-1:0]);
    assign pgm_we  = bus_we && (bus_addr == OFF_PGM) && !busy;

    fpc_lock #(.KEY_W(16), .KEY(UNLOCK_KEY)) i_lock (
        .clk        (clk),
        .rst        (rst),
        .lock_we    (bus_we && bus_addr == OFF_LOCK),
        .lock_wdata (bus_wdata[15:0]),
        .locked     (locked)
    );

    fpc_check #(.KS_ROW_LO(KS_ROW_LO), .KS_ROW_HI(KS_ROW_HI)) i_check (
        .word    (word_in),
        .locked  (locked),
        .pgm_en  (cfg_en),
        .hd_lock (hd_lock_fuse),
        .ks_lock (ks_wr_lock),
        .result  (chk),
        .arr     (chk_arr),
        .bidx    (chk_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_en     <= 1'b0;
            word_q     <= '0;
            busy       <= 1'b0;
            fuse_array <= '0;
            fuse_bit   <= '0;
        end else begin
            if (bus_we && bus_addr == OFF_CFG && !locked)
                cfg_en <= bus_wdata[1];
            if (pgm_we && !locked)
                word_q <= word_in;
            if (pgm_we && chk == CHK_PASS) begin
                busy       <= 1'b1;
                fuse_array <= chk_arr;
                fuse_bit   <= chk_bit;
            end else if (busy && fuse_ack) begin
                busy <= 1'b0;
            end
        end
    end

    always_comb begin
        ev_valid = 1'b0;
        ev_err   = 1'b0;
        if (busy && fuse_ack) begin
            ev_valid = 1'b1;
            ev_err   = !fuse_ok;
        end else if (pgm_we && chk != CHK_PASS) begin
            ev_valid = 1'b1;
            ev_err   = 1'b1;
        end
    end

    fpc_status #(.NFLAG(NFLAG)) i_status (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev_err    (ev_err),
        .w1c_we    (bus_we && bus_addr == OFF_STAT && !locked),
        .w1c_bits  (bus_wdata[NFLAG-1:0]),
        .mask_we   (bus_we && bus_addr == OFF_MASK && !locked),
        .mask_bits (bus_wdata[NFLAG-1:0]),
        .flags     (flags),
        .mask      (mask),
        .irq       (irq)
    );

    assign fuse_req = busy;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_LOCK: bus_rdata[0]          = locked;
            OFF_CFG:  bus_rdata[1]          = cfg_en;
            OFF_PGM:  bus_rdata[WORD_W-1:0] = word_q;
            OFF_STAT: bus_rdata[2:0]        = {busy, flags};
            OFF_MASK: bus_rdata[NFLAG-1:0]  = mask;
            default:  bus_rdata = '0;
        endcase
    end

    a_r4_no_burn_locked: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(locked));
    a_r5_no_burn_disabled: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_en));
    a_r2_array_range: assert property (@(posedge clk) disable iff (rst)
        fuse_req |-> fuse_array != 2'd3);
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !fuse_ack) |=> busy && $stable(fuse_bit) && $stable(fuse_array));
    a_r8_ack_done: assert property (@(posedge clk) disable iff (rst)
        (busy && fuse_ack) |=> !busy && flags[0]);
endmodule

// File: tb/test_fuse_prog_ctrl.sv
module test_fuse_prog_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hd_lock_fuse = 1'b0;
    logic        ks_wr_lock = 1'b0;
    logic        fuse_req;
    logic [1:0]  fuse_array;
    logic [10:0] fuse_bit;
    logic        fuse_ack = 1'b0;
    logic        fuse_ok = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    localparam logic [7:0] A_LOCK = 8'h00, A_CFG = 8'h04, A_PGM = 8'h08,
                           A_STAT = 8'h0C, A_MASK = 8'h10;

    always #4 clk = ~clk;

    fuse_prog_ctrl i_fuse_prog_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hd_lock_fuse(hd_lock_fuse), .ks_wr_lock(ks_wr_lock),
        .fuse_req(fuse_req), .fuse_array(fuse_array), .fuse_bit(fuse_bit),
        .fuse_ack(fuse_ack), .fuse_ok(fuse_ok), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input logic ok);
        @(negedge clk);
        fuse_ack = 1'b1; fuse_ok = ok;
        @(posedge clk);
        @(negedge clk);
        fuse_ack = 1'b0;
    endtask

    function automatic logic [31:0] pword(input int sel, input int row, input int col);
        return (32'(sel) << 11) | (32'(row) << 5) | 32'(col);
    endfunction

    function automatic logic exp_accept(input int sel, input int row, input logic lk,
                                        input logic en, input logic hd, input logic ks);
        if (sel == 1) return 1'b0;
        if (lk) return 1'b0;
        if (!en) return 1'b0;
        if (sel >= 2 && hd) return 1'b0;
        if (sel == 0 && ks && row >= 24 && row <= 31) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [1:0] exp_arr(input int sel);
        return (sel == 0) ? 2'd0 : 2'(sel - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_LOCK, d); check("R1 lock", d, 32'd1);
        rd(A_CFG, d);  check("R1 cfg", d, 32'd0);
        rd(A_STAT, d); check("R1 status", d, 32'd0);
        rd(A_MASK, d); check("R1 mask", d, 32'd3);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 fuse_req", {31'd0, fuse_req}, 32'd0);

        // R4 locked writes ignored, programming refused
        wr(A_CFG, 32'h2); rd(A_CFG, d); check("R4 cfg locked", d, 32'd0);
        wr(A_MASK, 32'h0); rd(A_MASK, d); check("R4 mask locked", d, 32'd3);
        wr(A_PGM, pword(0, 3, 4));
        check("R4 no req", {31'd0, fuse_req}, 32'd0);
        rd(A_STAT, d); check("R4 refused", d, 32'd3);
        wr(A_STAT, 32'h3); rd(A_STAT, d); check("R4 w1c locked", d, 32'd3);

        // R3 key handling
        wr(A_LOCK, 32'hFFFF_DF0D); rd(A_LOCK, d); check("R3 unlock", d, 32'd0);
        wr(A_LOCK, 32'h0000_1234); rd(A_LOCK, d); check("R3 relock", d, 32'd1);
        wr(A_LOCK, 32'h0000_DF0D); rd(A_LOCK, d); check("R3 unlock again", d, 32'd0);

        // R10 w1c of done only
        wr(A_STAT, 32'h1); rd(A_STAT, d); check("R10 clear done", d, 32'd2);
        // R11 mask and irq
        wr(A_MASK, 32'h1); check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h2); check("R11 irq err", {31'd0, irq}, 32'd1);
        rd(A_MASK, d); check("R11 mask rd", d, 32'd2);
        wr(A_STAT, 32'h2); check("R11 irq cleared", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h3);

        // R5 enable off
        wr(A_PGM, pword(0, 2, 2));
        check("R5 no req", {31'd0, fuse_req}, 32'd0);
        rd(A_STAT, d); check("R5 refused", d, 32'd3);
        wr(A_STAT, 32'h3);
        wr(A_CFG, 32'h2); rd(A_CFG, d); check("R5 cfg rd", d, 32'd2);

        // R2 select 1 invalid
        wr(A_PGM, pword(1, 5, 5));
        check("R2 sel1 no req", {31'd0, fuse_req}, 32'd0);
        rd(A_STAT, d); check("R9 sel1 refused", d, 32'd3);
        wr(A_STAT, 32'h3);

        // R12 busy ignores program writes
        wr(A_PGM, pword(3, 63, 31));
        check("R8 req", {31'd0, fuse_req}, 32'd1);
        check("R2 arr", {30'd0, fuse_array}, 32'd2);
        check("R2 bit", {21'd0, fuse_bit}, 32'd2047);
        rd(A_STAT, d); check("R12 busy", d, 32'd4);
        wr(A_PGM, pword(0, 1, 1));
        check("R12 bit held", {21'd0, fuse_bit}, 32'd2047);
        rd(A_STAT, d); check("R12 status unchanged", d, 32'd4);
        ack(1'b0);
        rd(A_STAT, d); check("R8 burn fail", d, 32'd3);
        check("R8 req drop", {31'd0, fuse_req}, 32'd0);
        wr(A_STAT, 32'h3);

        // Random mix covering R2 R5 R6 R7 R8 R9
        for (int i = 0; i < 300; i++) begin
            int sel = int'($urandom % 4);
            int row = ($urandom % 2) ? 24 + int'($urandom % 8) : int'($urandom % 64);
            int col = int'($urandom % 32);
            logic en = 1'($urandom % 4 != 0);
            logic hd = 1'($urandom % 2);
            logic ks = 1'($urandom % 2);
            logic lk = 1'($urandom % 6 == 0);
            logic ok = 1'($urandom % 4 != 0);
            logic acc;
            wr(A_LOCK, 32'hDF0D);
            wr(A_CFG, {30'd0, en, 1'b0});
            wr(A_STAT, 32'h3);
            hd_lock_fuse = hd; ks_wr_lock = ks;
            if (lk) wr(A_LOCK, 32'h0);
            acc = exp_accept(sel, row, lk, en, hd, ks);
            wr(A_PGM, pword(sel, row, col));
            check("R6 R7 accept", {31'd0, fuse_req}, {31'd0, acc});
            if (acc && fuse_req) begin
                check("R2 rnd arr", {30'd0, fuse_array}, {30'd0, exp_arr(sel)});
                check("R2 rnd bit", {21'd0, fuse_bit}, 32'(row * 32 + col));
                ack(ok);
                rd(A_STAT, d); check("R8 rnd status", d, {30'd0, !ok, 1'b1});
            end else if (acc) begin
                ack(ok);
            end else begin
                rd(A_STAT, d); check("R9 rnd status", d, 32'd3);
            end
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule